// File: doc/BRIEF.md
# Two-Wire Register Slave with Stop-Committed Writes

This block is the serial slave that gives a host access to the register bank of a power-management controller. It oversamples the bus clock and data lines in the system clock domain, cleans them, and finds start and stop conditions. It then answers only its own 7-bit device address. A write sets a register pointer and queues data bytes. A read returns register contents, starting at the current pointer.

Write data does not reach the registers byte by byte. It waits in a small staging buffer and lands in the bank in one system cycle, when the stop condition arrives. A transfer that is cut short by a new start or by the bus-side reset therefore leaves the bank untouched. The slave only ever pulls the data line low, for acknowledge bits and for read bits of value 0. Both bus lines are assumed to idle high through pull-ups.

Top module: `pmic_i2c_slave`

## Requirements
- R1: Each bus line passes through a two-flop synchronizer and a filter that takes a new level only after two matching samples, so a pulse lasting one system clock on either line has no effect.
- R2: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. A data change during clock-high is never read as a data bit, and a start in the middle of a transfer (repeated start) begins a new address phase.
- R3: The address byte carries the device address 7'b1001111 MSB first, with the direction bit last (0 = write, 1 = read). On a match the slave pulls the data line low during the ninth clock.
- R4: On an address mismatch the slave does not acknowledge, leaves the data line released for the rest of the transfer and ignores all bytes until the next start. The registers are not changed.
- R5: In a write, the first byte after the address loads the register pointer from its low log2(NREG) bits and is acknowledged. Each further byte is acknowledged, staged for the current pointer, and advances the pointer, which wraps modulo NREG.
- R6: Staged bytes appear on `reg_q` only after a stop condition, all at once. Before the stop the register contents do not change.
- R7: The staging buffer holds STAGE_DEPTH bytes. A further data byte in the same write is not acknowledged and is dropped.
- R8: In a read, the slave sends the register at the pointer MSB first, on clock-low phases, and advances the pointer after each byte. A master acknowledge (0) asks for the next byte. A master non-acknowledge (1) makes the slave release the line until the next start or stop.
- R9: A repeated start keeps the register pointer but discards every staged byte, so no commit follows.
- R10: A stop always returns the slave to idle. The slave never pulls the data line during bits driven by the master, and it changes its pull only while the clock line is low.
- R11: While `bus_rst_n` is low the interface is idle, staged data is cleared, the pointer is 0 and no commit happens. The register contents are kept.
- R12: While `rst_n` is low all registers read 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| bus_rst_n | input | 1 | Synchronous active-low interface reset; keeps register contents |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 = drive the data line low; 0 = release it |
| reg_q | output | NREG*8 | Register bank contents, register k in bits [8k+7:8k] |

## Verification
The stop condition and the interface reset can act in the same system cycle. The commit then competes with the clearing of the staging buffer. The bench provokes this by holding `bus_rst_n` low across the whole stop sequence of a write that has staged bytes, so the stop is detected while the reset is asserted. It judges the outcome by comparing `reg_q` on every clock with a behavioural model, which must show no commit. A following read must then return register 0, which confirms that the pointer was cleared.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-wire register slave.
// Assumes: one byte-engine state machine; states are only compared, never decoded by value outside.
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a start (also used after an address mismatch)
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_ACK,  // driving the address acknowledge
        ST_WR_BYTE,   // shifting in a pointer or data byte
        ST_WR_ACK,    // driving (or withholding) the data acknowledge
        ST_RD_BYTE,   // driving read data bits
        ST_RD_ACK,    // sampling the master acknowledge
        ST_RD_NEXT    // master acked, load next byte at clock fall
    } eng_state_t;
endpackage

// File: rtl/i2cs_line_filter.sv
`timescale 1ns/1ps
// Brings one asynchronous bus line into the clk domain and removes single-sample glitches.
// Assumes: the line idles high; the output follows the input about three clocks late.
module i2cs_line_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    logic [1:0] sync_q;
    logic       agree_q;

    // Synchronize, then accept a new level only when two consecutive samples match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            agree_q <= 1'b1;
            filt    <= 1'b1;
        end else begin
            sync_q  <= {sync_q[0], raw};
            agree_q <= sync_q[1];
            if (sync_q[1] == agree_q) filt <= sync_q[1];
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
`timescale 1ns/1ps
// Turns filtered clock/data levels into single-cycle bus events.
// Assumes: inputs are already synchronous and glitch-free.
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
// Bit/byte protocol engine: address match, pointer load, staging requests, read data drive.
// Assumes: at most one of start/stop/rise/fall per cycle; the pull output changes only after a clock fall.
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001111,
    parameter int         PW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst_n,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          scl_lvl,
    input  logic          sda_bit,
    input  logic [7:0]    rd_byte,
    input  logic          stg_full,
    output logic [PW-1:0] ptr,
    output logic          stg_push,
    output logic [7:0]    stg_data,
    output logic          stg_clear,
    output logic          commit,
    output logic          sda_pull
);
    eng_state_t state;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txbyte;
    logic       rw, first;

    assign stg_data  = shreg;
    assign stg_clear = start_ev | ~bus_rst_n;
    assign commit    = stop_ev & bus_rst_n;
    assign stg_push  = bus_rst_n & scl_fall & (state == ST_WR_BYTE) & (bitcnt == 4'd8)
                       & ~first & ~stg_full;

    // Protocol state machine; sample on clock rise, drive on clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_rst_n) begin
            state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txbyte <= '0;
            rw <= 1'b0; first <= 1'b0; ptr <= '0; sda_pull <= 1'b0;
        end else if (start_ev) begin
            state <= ST_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
        end else if (stop_ev) begin
            state <= ST_IDLE; bitcnt <= '0; sda_pull <= 1'b0;
        end else if (scl_rise) begin
            case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    shreg  <= {shreg[6:0], sda_bit};
                    bitcnt <= bitcnt + 4'd1;
                end
                ST_RD_BYTE: bitcnt <= bitcnt + 4'd1;
                ST_RD_ACK:  state <= sda_bit ? ST_IDLE : ST_RD_NEXT;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (state)
                ST_ADDR: if (bitcnt == 4'd8) begin
                    if (shreg[7:1] == DEV_ADDR) begin
                        sda_pull <= 1'b1; rw <= shreg[0]; state <= ST_ADDR_ACK;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR_ACK, ST_RD_NEXT: begin
                    bitcnt <= '0;
                    if (rw || state == ST_RD_NEXT) begin
                        txbyte <= rd_byte; sda_pull <= ~rd_byte[7]; state <= ST_RD_BYTE;
                    end else begin
                        sda_pull <= 1'b0; first <= 1'b1; state <= ST_WR_BYTE;
                    end
                end
                ST_WR_BYTE: if (bitcnt == 4'd8) begin
                    state <= ST_WR_ACK;
                    if (first) begin
                        ptr <= shreg[PW-1:0]; first <= 1'b0; sda_pull <= 1'b1;
                    end else if (!stg_full) begin
                        ptr <= ptr + PW'(1); sda_pull <= 1'b1;
                    end else begin
                        sda_pull <= 1'b0;
                    end
                end
                ST_WR_ACK: begin
                    sda_pull <= 1'b0; bitcnt <= '0; state <= ST_WR_BYTE;
                end
                ST_RD_BYTE: begin
                    if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0; ptr <= ptr + PW'(1); state <= ST_RD_ACK;
                    end else begin
                        sda_pull <= ~txbyte[3'd7 - bitcnt[2:0]];
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_n && $past(bus_rst_n) && (sda_pull != $past(sda_pull))) |-> !scl_lvl);
    // R2
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && bus_rst_n) |=> (state == ST_ADDR) && !sda_pull);
    // R10
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && bus_rst_n) |=> (state == ST_IDLE) && !sda_pull);
    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);
endmodule

// File: rtl/i2cs_regbank.sv
`timescale 1ns/1ps
// Register bank with a staging buffer that is written into the bank in one cycle on commit.
// Assumes: NREG is a power of two and STAGE_DEPTH <= NREG, so staged bytes map to distinct registers.
module i2cs_regbank #(
    parameter int NREG        = 8,
    parameter int STAGE_DEPTH = 4,
    localparam int PW = $clog2(NREG),
    localparam int SW = $clog2(STAGE_DEPTH),
    localparam int CW = $clog2(STAGE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     ptr,
    input  logic              push,
    input  logic [7:0]        push_data,
    input  logic              clear,
    input  logic              commit,
    output logic              full,
    output logic [7:0]        rd_byte,
    output logic [NREG*8-1:0] reg_flat
);
    logic [NREG-1:0][7:0]        regs_q;
    logic [STAGE_DEPTH-1:0][7:0] stage_q;
    logic [CW-1:0]               count;
    logic [PW-1:0]               base;
    logic [PW-1:0]               off [NREG];
    logic [NREG-1:0]             hit;

    assign full     = (count == CW'(STAGE_DEPTH));
    assign rd_byte  = regs_q[ptr];
    assign reg_flat = regs_q;

    // Staging buffer fill, clear on abort and empty after commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0; base <= '0; stage_q <= '0;
        end else if (clear || commit) begin
            count <= '0;
        end else if (push && !full) begin
            for (int i = 0; i < STAGE_DEPTH; i++)
                if (32'(count) == i) stage_q[i] <= push_data;
            if (count == '0) base <= ptr;
            count <= count + CW'(1);
        end
    end

    // Map every register to its slot in the staging buffer.
    for (genvar r = 0; r < NREG; r++) begin : g_map
        assign off[r] = PW'(r) - base;
        assign hit[r] = commit && (32'(off[r]) < 32'(count));
    end

    // Apply all staged bytes at once on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int r = 0; r < NREG; r++)
                if (hit[r]) regs_q[r] <= stage_q[off[r][SW-1:0]];
        end
    end

    // R7
    stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(STAGE_DEPTH));
    // R6
    hold_until_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs_q));
endmodule

// File: rtl/pmic_i2c_slave.sv
`timescale 1ns/1ps
// Top of the two-wire register slave: line filters, event detector, protocol engine, register bank.
// Assumes: pull-ups outside; sda_pull drives an open-drain pad; bus phases last at least ~8 clk cycles.
module pmic_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1001111,
    parameter int         NREG        = 8,
    parameter int         STAGE_DEPTH = 4,
    localparam int        PW          = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [NREG*8-1:0] reg_q
);
    logic [1:0]    raw, filt;
    logic          start_ev, stop_ev, scl_rise, scl_fall;
    logic [7:0]    rd_byte, stg_data;
    logic          stg_full, stg_push, stg_clear, commit;
    logic [PW-1:0] ptr;

    assign raw = {sda_in, scl_in};

    // One filter per bus line: index 0 clock, index 1 data.
    for (genvar i = 0; i < 2; i++) begin : g_line
        i2cs_line_filter u_filt (.clk(clk), .rst_n(rst_n), .raw(raw[i]), .filt(filt[i]));
    end

    i2cs_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(filt[0]), .sda_f(filt[1]),
        .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2cs_engine #(.DEV_ADDR(DEV_ADDR), .PW(PW)) u_engine (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .scl_lvl(filt[0]), .sda_bit(filt[1]), .rd_byte(rd_byte), .stg_full(stg_full),
        .ptr(ptr), .stg_push(stg_push), .stg_data(stg_data), .stg_clear(stg_clear),
        .commit(commit), .sda_pull(sda_pull)
    );

    i2cs_regbank #(.NREG(NREG), .STAGE_DEPTH(STAGE_DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .push(stg_push), .push_data(stg_data),
        .clear(stg_clear), .commit(commit), .full(stg_full), .rd_byte(rd_byte),
        .reg_flat(reg_q)
    );
endmodule

// File: tb/test_pmic_i2c_slave.sv
`timescale 1ns/1ps
module test_pmic_i2c_slave;
    localparam logic [6:0] DEV = 7'b1001111;
    localparam int NREG = 8;
    localparam int DEPTH = 4;
    localparam int Q = 24;

    logic clk = 1'b0;
    logic rst_n, bus_rst_n, scl_m, sda_m, g_sda, g_scl, sda_pull;
    logic [NREG*8-1:0] reg_q;
    wire scl_in = scl_m ^ g_scl;
    wire sda_in = (sda_m & ~sda_pull) ^ g_sda;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 0, glitch_on = 0, done = 0;
    logic [7:0] m_regs [NREG];
    logic [7:0] m_stage [$];
    int m_ptr = 0, m_base = 0;
    logic [7:0] tx [8];

    always #2.5 clk = ~clk;

    pmic_i2c_slave i_pmic_i2c_slave (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .scl_in(scl_in),
        .sda_in(sda_in), .sda_pull(sda_pull), .reg_q(reg_q)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] m_flat();
        logic [63:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_regs[i];
        return v;
    endfunction

    // Register bank compared with the model on every clock (R6).
    always @(negedge clk) if (cmp_en) check("R6", reg_q, m_flat());

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, input logic exp_bus, input string req);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q / 2);
        if (glitch_on) begin g_sda = 1'b1; wq(1); g_sda = 1'b0; end
        wq(Q / 2); check(req, sda_in, exp_bus); wq(Q);
        scl_m = 1'b0; wq(Q / 2);
        if (glitch_on) begin g_scl = 1'b1; wq(1); g_scl = 1'b0; end
        wq(Q / 2);
    endtask

    task automatic byte_out(input logic [7:0] b, input bit ack, input string req);
        for (int i = 7; i >= 0; i--) bit_io(b[i], b[i], "R10");
        bit_io(1'b1, !ack, req);
    endtask

    task automatic byte_in(input logic [7:0] exp, input bit mack, input string req);
        for (int i = 7; i >= 0; i--) bit_io(1'b1, exp[i], req);
        bit_io(!mack, !mack, "R10");
    endtask

    task automatic do_start();
        if (!scl_m) begin sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); end
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
        m_stage.delete();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
        cmp_en = 0; sda_m = 1'b1;
        if (bus_rst_n) for (int i = 0; i < m_stage.size(); i++) m_regs[(m_base + i) % NREG] = m_stage[i];
        m_stage.delete();
        wq(Q); cmp_en = 1; wq(Q);
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] p, input int n, input bit stop);
        bit hit = (dev == DEV);
        do_start();
        byte_out({dev, 1'b0}, hit, hit ? "R3" : "R4");
        if (!hit) begin
            byte_out(p, 1'b0, "R4");
            for (int i = 0; i < n; i++) byte_out(tx[i], 1'b0, "R4");
        end else begin
            byte_out(p, 1'b1, "R5");
            m_ptr = p % NREG; m_base = m_ptr;
            for (int i = 0; i < n; i++) begin
                if (m_stage.size() < DEPTH) begin
                    m_stage.push_back(tx[i]); m_ptr = (m_ptr + 1) % NREG;
                    byte_out(tx[i], 1'b1, "R5");
                end else begin
                    byte_out(tx[i], 1'b0, "R7");
                end
            end
        end
        if (stop) do_stop();
    endtask

    task automatic read_txn(input int n, input string req);
        do_start();
        byte_out({DEV, 1'b1}, 1'b1, "R2");
        for (int k = 0; k < n; k++) begin
            logic [7:0] e = m_regs[m_ptr];
            m_ptr = (m_ptr + 1) % NREG;
            byte_in(e, k != n - 1, req);
        end
        do_stop();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) m_regs[i] = 8'h00;
        rst_n = 1'b0; bus_rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1; g_sda = 1'b0; g_scl = 1'b0;
        wq(5);
        check("R12", {63'd0, sda_pull}, 64'd0);
        check("R12", reg_q, 64'd0);
        rst_n = 1'b1; wq(10);
        check("R12", reg_q, 64'd0);
        cmp_en = 1;
        // plain write of two bytes at pointer 3
        tx[0] = 8'hA5; tx[1] = 8'h3C;
        write_txn(DEV, 8'h03, 2, 1);
        // pointer set, repeated start, read three bytes
        write_txn(DEV, 8'h02, 0, 0);
        read_txn(3, "R8");
        // wrong address is ignored
        tx[0] = 8'hFF;
        write_txn(7'b1001110, 8'h00, 1, 1);
        // overflow of the staging buffer with pointer wrap
        for (int i = 0; i < 6; i++) tx[i] = 8'(8'h10 + 8'(i) * 8'h11);
        write_txn(DEV, 8'h2E, 6, 1);
        write_txn(DEV, 8'h06, 0, 0);
        read_txn(4, "R5");
        // abort by repeated start: staged bytes discarded, pointer kept
        tx[0] = 8'hDE; tx[1] = 8'hAD;
        write_txn(DEV, 8'h05, 2, 0);
        read_txn(2, "R9");
        // glitches on both lines
        glitch_on = 1;
        tx[0] = 8'h5A; tx[1] = 8'hC3; tx[2] = 8'h81;
        write_txn(DEV, 8'h01, 3, 1);
        glitch_on = 0;
        check("R1", reg_q, m_flat());
        // interface reset held across the stop
        tx[0] = 8'h77; tx[1] = 8'h99;
        write_txn(DEV, 8'h04, 2, 0);
        bus_rst_n = 1'b0; m_stage.delete(); m_ptr = 0;
        do_stop();
        bus_rst_n = 1'b1; wq(Q);
        check("R11", reg_q, m_flat());
        read_txn(1, "R11");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule